// File: doc/BRIEF.md
# PWM Speed Input Conditioner

This block turns a raw speed command into the control flags that a three-phase low-side gate driver needs. The digital speed pulse is active low: while it is low the low-side switches may be driven, and while it is high they are off. The pulse passes through a two-flop synchronizer before any timing is applied to it. A second input is a flag from an external comparator path. That flag reports that the analog speed level is below the zero-duty threshold. If either source stays in its "no drive" state for a full zero-duty timeout, the block declares zero duty. It then releases the phases to coast or applies a short brake, depending on the mode code.

The block also measures the command pulse itself. It times the interval from one on-time start to the next, and it times the length of each on-time. Using these two measurements it flags a low command rate, and the fan-style behaviour uses that flag to withhold synchronous rectification. A two-bit mode code selects fan-style or office-style behaviour and selects whether the Hall-sensor bias may be switched off to save power. All timeouts are set in clock cycles, derived from a clock-frequency parameter and time parameters.

Top module: `spdin_cond`

## Requirements
- R1: With no zero duty, no brake request and no stall, `gate_en` equals the inverse of `pwm_in`, delayed by the two synchronizer flops. Over one steady command period, `gate_en` is high for exactly the number of cycles `pwm_in` was low.
- R2: `duty_zero` rises after `pwm_in` has been high for ZERO_CYC consecutive synchronized cycles. If `pwm_in` changes at a falling clock edge, `duty_zero` is high after the (ZERO_CYC+2)-th rising edge and still low after the (ZERO_CYC+1)-th. ZERO_CYC is CLK_HZ/1000 × ZERO_TIMEOUT_US / 1000.
- R3: `duty_zero` rises after `ana_low` has been high for ZERO_CYC consecutive cycles, and the zero state from this path clears one cycle after `ana_low` falls.
- R4: A zero state that came from the pulse path clears on the first synchronized low of `pwm_in`, three rising edges after the change. `duty_up` is high for exactly the single cycle after `duty_zero` falls.
- R5: The mode code `mode` is encoded as follows: 2'b00 is office-style with power saving, 2'b01 is office-style with the Hall bias always on, 2'b10 is fan-style with the Hall bias always on, and 2'b11 is fan-style with power saving. Bit 1 selects fan-style.
- R6: While `duty_zero` is high, the fan-style modes drive `freerun_req` high and leave `brake_out` low unless a brake is requested, and the office-style modes drive `brake_out` high. `freerun_req` is never high when `brake_req` is high.
- R7: `low_rate` is high when the last measured interval between on-time starts is at least PERIOD_CYC (CLK_HZ/MIN_FREQ_HZ), or when the last on-time was shorter than MIN_ON_CYC (CLK_HZ/1000 × MIN_ON_NS / 10^6). In the fan-style modes `sync_rect_ok` is low while `low_rate` or `duty_zero` is high. In the office-style modes `sync_rect_ok` is always high.
- R8: In the power-saving modes, `hall_bias_en` is low while `duty_zero`, `brake_req` or `stall` is high. In the other two modes it is always high.
- R9: `brake_req` or `stall` forces `gate_en` low, and `brake_req` forces `brake_out` high in every mode.
- R10: During and right after reset, `gate_en`, `duty_zero`, `duty_up` and `low_rate` are low, and `hall_bias_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Asynchronous speed pulse, low means drive |
| ana_low | input | 1 | Synchronous flag: analog speed level below zero threshold |
| mode | input | 2 | Behaviour and power-saving selection code |
| brake_req | input | 1 | Start/brake request, high means brake |
| stall | input | 1 | Stall protection active |
| gate_en | output | 1 | Low-side PWM enable |
| duty_zero | output | 1 | Zero duty declared |
| duty_up | output | 1 | One-cycle pulse when zero duty ends |
| low_rate | output | 1 | Command period too long or on-time too short |
| sync_rect_ok | output | 1 | Synchronous rectification permitted |
| hall_bias_en | output | 1 | Hall-sensor bias enable |
| brake_out | output | 1 | Short-brake request to the output stage |
| freerun_req | output | 1 | Release all phases to coast |

## Verification
The assertions check several properties on every cycle:
- a timeout flag rises only after its level was present;
- a saturated counter backs the timeout flag;
- the rate flag changes only at on-time ends or once the period limit is reached;
- the zero state from the pulse path clears only on a synchronized low;
- the restart pulse lasts one cycle.

Some results can only be shown by the bench's scenarios. These are the exact cycle at which zero duty is declared and cleared, the on-time count carried through the synchronizer, and the rate classification across a sweep of periods and on-times on both sides of both limits. The same holds for the full cross of the four mode codes with brake, stall and zero duty.

// File: rtl/spdin_pkg.sv
package spdin_pkg;

  typedef enum logic [1:0] {
    MD_OFFICE_SAVE = 2'b00,
    MD_OFFICE_TACH = 2'b01,
    MD_FAN_TACH    = 2'b10,
    MD_FAN_SAVE    = 2'b11
  } spd_mode_e;

  typedef struct packed {
    logic fan_style;
    logic low_power;
  } mode_cfg_t;

  function automatic mode_cfg_t decode_mode(input logic [1:0] code);
    mode_cfg_t cfg;
    case (spd_mode_e'(code))
      MD_OFFICE_SAVE: cfg = '{fan_style: 1'b0, low_power: 1'b1};
      MD_OFFICE_TACH: cfg = '{fan_style: 1'b0, low_power: 1'b0};
      MD_FAN_TACH:    cfg = '{fan_style: 1'b1, low_power: 1'b0};
      default:        cfg = '{fan_style: 1'b1, low_power: 1'b1};
    endcase
    return cfg;
  endfunction

endpackage

// File: rtl/spdin_sync.sv
module spdin_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stg_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= RST_VAL;
        else        stg_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[i] <= RST_VAL;
        else        stg_q[i] <= stg_q[i-1];
      end
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/spdin_level_timer.sv
// Counts consecutive cycles of a level; flags expiry once LIMIT is reached
// and drops the flag in the cycle after the level goes away.
module spdin_level_timer #(
  parameter int LIMIT = 125000,
  parameter int REQ   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic expired
);

  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM_C = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (lvl) begin
      if (cnt_q != LIM_C) cnt_d = cnt_q + CW'(1);
      exp_d = exp_q | (cnt_d == LIM_C);
    end else begin
      cnt_d = '0;
      exp_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;

  // REQ selects which requirement tag the checks report under
  if (REQ == 2) begin : g_chk_pulse
    assert_rise_needs_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_q) |-> $past(lvl));
    assert_expiry_saturated_R2: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |-> (cnt_q == LIM_C));
  end else begin : g_chk_level
    assert_rise_needs_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(exp_q) |-> $past(lvl));
    assert_expiry_saturated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      exp_q |-> (cnt_q == LIM_C));
  end

endmodule

// File: rtl/spdin_rate_mon.sv
// Measures on-start to on-start interval and on-time of the synchronized
// active-low command and flags a slow or very narrow command.
module spdin_rate_mon #(
  parameter int PERIOD_CYC = 6666,
  parameter int MIN_ON_CYC = 75
) (
  input  logic clk,
  input  logic rst_n,
  input  logic s_pwm,
  output logic low_rate
);

  localparam int PW = $clog2(PERIOD_CYC + 1);
  localparam int OW = $clog2(MIN_ON_CYC + 1);
  localparam logic [PW-1:0] PMAX = PW'(PERIOD_CYC);
  localparam logic [OW-1:0] OMIN = OW'(MIN_ON_CYC);

  logic          s_d_q;
  logic [PW-1:0] per_q, per_d;
  logic [OW-1:0] on_q, on_d;
  logic          slow_q, slow_d;
  logic          narrow_q, narrow_d;
  logic          on_start, on_end;

  assign on_start = s_d_q & ~s_pwm;
  assign on_end   = ~s_d_q & s_pwm;

  always_comb begin
    per_d    = per_q;
    slow_d   = slow_q;
    on_d     = on_q;
    narrow_d = narrow_q;
    if (on_start) begin
      per_d  = PW'(1);
      slow_d = (per_q == PMAX);
    end else begin
      if (per_q != PMAX) per_d = per_q + PW'(1);
      slow_d = slow_q | (per_q == PMAX);
    end
    if (s_pwm) begin
      on_d = '0;
      if (on_end) narrow_d = (on_q < OMIN);
    end else if (on_q != OMIN) begin
      on_d = on_q + OW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_d_q    <= 1'b1;
      per_q    <= '0;
      on_q     <= '0;
      slow_q   <= 1'b0;
      narrow_q <= 1'b0;
    end else begin
      s_d_q    <= s_pwm;
      per_q    <= per_d;
      on_q     <= on_d;
      slow_q   <= slow_d;
      narrow_q <= narrow_d;
    end
  end

  assign low_rate = slow_q | narrow_q;

  assert_slow_needs_limit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slow_q) |-> ($past(per_q) == PMAX));
  assert_narrow_at_on_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(narrow_q) |-> $past(on_end));

endmodule

// File: rtl/spdin_cond.sv
module spdin_cond
  import spdin_pkg::*;
#(
  parameter int CLK_HZ          = 50_000_000,
  parameter int ZERO_TIMEOUT_US = 2500,
  parameter int MIN_FREQ_HZ     = 7500,
  parameter int MIN_ON_NS       = 1500,
  parameter int SYNC_STAGES     = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pwm_in,
  input  logic       ana_low,
  input  logic [1:0] mode,
  input  logic       brake_req,
  input  logic       stall,
  output logic       gate_en,
  output logic       duty_zero,
  output logic       duty_up,
  output logic       low_rate,
  output logic       sync_rect_ok,
  output logic       hall_bias_en,
  output logic       brake_out,
  output logic       freerun_req
);

  localparam int KHZ        = CLK_HZ / 1000;
  localparam int ZERO_CYC   = KHZ * ZERO_TIMEOUT_US / 1000;
  localparam int PERIOD_CYC = CLK_HZ / MIN_FREQ_HZ;
  localparam int MIN_ON_CYC = KHZ * MIN_ON_NS / 1_000_000;

  mode_cfg_t cfg;
  logic      s_pwm;
  logic      pwm_zero, ana_zero;
  logic      zero_d_q;

  assign cfg = decode_mode(mode);

  spdin_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pwm_in),
    .q    (s_pwm)
  );

  spdin_level_timer #(.LIMIT(ZERO_CYC), .REQ(2)) u_pwm_zero (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (s_pwm),
    .expired(pwm_zero)
  );

  spdin_level_timer #(.LIMIT(ZERO_CYC), .REQ(3)) u_ana_zero (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl    (ana_low),
    .expired(ana_zero)
  );

  spdin_rate_mon #(.PERIOD_CYC(PERIOD_CYC), .MIN_ON_CYC(MIN_ON_CYC)) u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_pwm   (s_pwm),
    .low_rate(low_rate)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) zero_d_q <= 1'b0;
    else        zero_d_q <= duty_zero;
  end

  always_comb begin
    duty_zero    = pwm_zero | ana_zero;
    duty_up      = zero_d_q & ~duty_zero;
    gate_en      = ~s_pwm & ~duty_zero & ~brake_req & ~stall;
    sync_rect_ok = cfg.fan_style ? ~(low_rate | duty_zero) : 1'b1;
    hall_bias_en = ~(cfg.low_power & (duty_zero | brake_req | stall));
    brake_out    = brake_req | (duty_zero & ~cfg.fan_style);
    freerun_req  = duty_zero & cfg.fan_style & ~brake_req;
  end

  assert_pulse_zero_clears_on_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm_zero) |-> !$past(s_pwm));
  assert_up_single_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    duty_up |=> !duty_up);
  assert_no_coast_while_brake_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(freerun_req && brake_out));

endmodule

// File: tb/spdin_cond_tb.sv
`timescale 1ns/1ps
module spdin_cond_tb;

  localparam int ZC = 40;  // zero timeout in cycles for this configuration
  localparam int PC = 20;  // period limit in cycles
  localparam int MC = 3;   // minimum on-time in cycles

  logic       clk = 1'b0;
  logic       rst_n;
  logic       pwm_in, ana_low, brake_req, stall;
  logic [1:0] mode;
  logic       gate_en, duty_zero, duty_up, low_rate, sync_rect_ok;
  logic       hall_bias_en, brake_out, freerun_req;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spdin_cond #(
    .CLK_HZ(1_000_000), .ZERO_TIMEOUT_US(40), .MIN_FREQ_HZ(50_000), .MIN_ON_NS(3000)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .ana_low(ana_low), .mode(mode),
    .brake_req(brake_req), .stall(stall), .gate_en(gate_en), .duty_zero(duty_zero),
    .duty_up(duty_up), .low_rate(low_rate), .sync_rect_ok(sync_rect_ok),
    .hall_bias_en(hall_bias_en), .brake_out(brake_out), .freerun_req(freerun_req)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one command period: lo cycles driven low, then per-lo cycles high;
  // returns number of sampled gate_en highs
  task automatic one_period(input int per, input int lo, output int ons);
    ons = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      ons += int'(gate_en);
      pwm_in = (i < lo) ? 1'b0 : 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int plist [6] = '{8, 12, 19, 20, 21, 25};
    int ons;
    rst_n = 1'b0; pwm_in = 1'b1; ana_low = 1'b0; brake_req = 1'b0; stall = 1'b0;
    mode = 2'b10;
    cyc(3);
    check("R10", "gate_en in reset", gate_en, 0);
    check("R10", "hall_bias_en in reset", hall_bias_en, 1);
    rst_n = 1'b1;
    cyc(1);
    check("R10", "duty_zero after reset", duty_zero, 0);
    check("R10", "duty_up after reset", duty_up, 0);
    check("R10", "low_rate after reset", low_rate, 0);
    check("R10", "gate_en after reset", gate_en, 0);

    // R1 / R7 sweep over period and on-time in both behaviour styles
    for (int m = 0; m < 2; m++) begin
      mode = (m == 0) ? 2'b10 : 2'b01;
      for (int pi = 0; pi < 6; pi++) begin
        for (int lo = 1; lo <= 5; lo++) begin
          bit exp_low;
          for (int k = 0; k < 4; k++) one_period(plist[pi], lo, ons);
          one_period(plist[pi], lo, ons);
          exp_low = (plist[pi] >= PC) || (lo < MC);
          check("R1", $sformatf("gate on-count P=%0d L=%0d", plist[pi], lo), ons, lo);
          check("R7", $sformatf("low_rate P=%0d L=%0d", plist[pi], lo), low_rate, int'(exp_low));
          check("R7", $sformatf("sync_rect_ok mode=%0d P=%0d L=%0d", mode, plist[pi], lo),
                sync_rect_ok, (mode[1]) ? int'(!exp_low) : 1);
        end
      end
    end

    // R2 / R4 pulse-path zero duty in fan-style mode
    mode = 2'b10;
    @(negedge clk); pwm_in = 1'b0;
    cyc(10);
    pwm_in = 1'b1;
    cyc(ZC + 1);
    check("R2", "duty_zero one cycle early", duty_zero, 0);
    cyc(1);
    check("R2", "duty_zero at timeout", duty_zero, 1);
    check("R6", "freerun_req at zero fan-style", freerun_req, 1);
    check("R6", "brake_out at zero fan-style", brake_out, 0);
    check("R7", "sync_rect_ok at zero fan-style", sync_rect_ok, 0);
    check("R1", "gate_en at zero", gate_en, 0);
    cyc(5);
    pwm_in = 1'b0;
    cyc(2);
    check("R4", "duty_zero before clear", duty_zero, 1);
    check("R4", "duty_up before clear", duty_up, 0);
    cyc(1);
    check("R4", "duty_zero cleared on first low", duty_zero, 0);
    check("R4", "duty_up pulse", duty_up, 1);
    check("R1", "gate_en resumes", gate_en, 1);
    cyc(1);
    check("R4", "duty_up single cycle", duty_up, 0);

    // R3 analog-path zero duty, pulse input held low
    cyc(5);
    ana_low = 1'b1;
    cyc(ZC - 1);
    check("R3", "ana zero one cycle early", duty_zero, 0);
    cyc(1);
    check("R3", "ana zero at timeout", duty_zero, 1);
    cyc(3);
    ana_low = 1'b0;
    cyc(1);
    check("R3", "ana zero cleared", duty_zero, 0);
    check("R4", "duty_up after ana clear", duty_up, 1);

    // R5 R6 R8 R9: every mode code against zero duty, brake and stall
    for (int m = 0; m < 4; m++) begin
      for (int z = 0; z < 2; z++) begin
        mode = 2'(m);
        brake_req = 1'b0; stall = 1'b0;
        ana_low = 1'(z);
        cyc(ZC + 2);
        for (int b = 0; b < 2; b++) begin
          for (int s = 0; s < 2; s++) begin
            bit fan, save, e_hall, e_brk, e_free, e_gate;
            brake_req = 1'(b); stall = 1'(s);
            #2;
            fan    = (m >= 2);
            save   = (m == 0) || (m == 3);
            e_hall = !(save && (z || b || s));
            e_brk  = b || (z && !fan);
            e_free = z && fan && !b;
            e_gate = !z && !b && !s;
            check("R5", $sformatf("duty_zero m=%0d z=%0d", m, z), duty_zero, z);
            check("R8", $sformatf("hall_bias m=%0d z=%0d b=%0d s=%0d", m, z, b, s),
                  hall_bias_en, int'(e_hall));
            check("R6", $sformatf("brake_out m=%0d z=%0d b=%0d", m, z, b), brake_out, int'(e_brk));
            check("R6", $sformatf("freerun m=%0d z=%0d b=%0d", m, z, b), freerun_req, int'(e_free));
            check("R9", $sformatf("gate_en m=%0d z=%0d b=%0d s=%0d", m, z, b, s),
                  gate_en, int'(e_gate));
            cyc(1);
          end
        end
        ana_low = 1'b0; brake_req = 1'b0; stall = 1'b0;
        cyc(3);
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule